// File: doc/BRIEF.md
# Write-Allocate Decision Unit

This unit sits beside a data cache and is asked, for every pending write that misses, whether the cache should fetch the line and then merge the write (allocate) or let the write go straight to memory. Each write brings its byte address, a flag saying the address matched the tag of a valid sector, and a flag saying whether the addressed line inside that sector is itself valid. A 9-bit configuration word supplies a coarse upper address limit, an enable for the 15 MB to 16 MB window, and one reserved bit.

The decision is made by a fixed priority chain. The first rule is a hard exclusion of the legacy region from 000A_0000h to 000F_FFFFh, which is treated as non-cacheable. Next comes a sector hit whose addressed line is invalid. Then the 15–16 MB window is considered, but only when the limit reaches 16 MB. Last is a plain comparison against the limit. The outcome comes out registered one cycle after the write is presented, together with a 3-bit reason code for debug. A separate registered flag reports a reserved configuration bit set to 1.

A two-state controller paces the output. In ST_IDLE no decision is shown. Transition T_ACCEPT moves ST_IDLE to ST_ISSUE on a valid write. T_STREAM keeps the controller in ST_ISSUE while writes arrive back to back. T_DRAIN returns it to ST_IDLE on the first cycle with no write. T_WAIT keeps it in ST_IDLE while no write arrives.

Top module: `walloc_top`

## Requirements
- R1: A write with sector_hit=1 and line_valid=0 whose address is outside the excluded region gives dec_alloc=1 with dec_reason=1, whatever the limit and window enable.
- R2: A write outside the excluded region and outside the 15–16 MB window, that is not covered by R1, and whose address is below limit×4 MB (limit = cfg_word[6:0]) gives dec_alloc=1 with dec_reason=2.
- R3: A write whose address lies from 000A_0000h to 000F_FFFFh inclusive gives dec_alloc=0 with dec_reason=5, even when the R1 condition holds.
- R4: A write in 00F0_0000h–00FF_FFFFh that is not covered by R1, with limit ≥ 4 (16 MB) and cfg_word[7]=1, gives dec_alloc=1 with dec_reason=3.
- R5: A write in 00F0_0000h–00FF_FFFFh that is not covered by R1, with limit ≥ 4 and cfg_word[7]=0, gives dec_alloc=0 with dec_reason=4.
- R6: Any other write gives dec_alloc=0 with dec_reason=0. In particular, with limit < 4 the window enable has no effect, and with limit = 0 only R1 can allocate.
- R7: dec_valid is 1 exactly in the cycle after a cycle with wr_valid=1. When dec_valid is 0, dec_alloc is 0 and dec_reason is 0.
- R8: cfg_err equals the value of cfg_word[8] one cycle earlier, and that bit does not change any decision.
- R9: While rst_n is low, dec_valid, dec_alloc, dec_reason and cfg_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A missing write is presented this cycle |
| wr_addr | input | 32 | Byte address of the write |
| sector_hit | input | 1 | Address matched the tag of a valid sector |
| line_valid | input | 1 | Addressed line inside the sector is valid |
| cfg_word | input | 9 | [6:0] limit in 4 MB units, [7] window enable, [8] reserved |
| dec_valid | output | 1 | A decision is presented |
| dec_alloc | output | 1 | 1 = allocate, 0 = write through |
| dec_reason | output | 3 | Rule that decided: 0 above limit, 1 sector, 2 below limit, 3 window on, 4 window off, 5 excluded region |
| cfg_err | output | 1 | Reserved configuration bit was set |

## Verification
The sweep covers addresses at 64 KB steps across the first 2 MB, both ends of every 1 MB block up to 64 MB, the 508 MB limit boundary and the top of the address space. It runs each address against limits 0 to 17 and 127, both window enables and all four sector/line flag combinations. The 64 KB steps separate the edges of the excluded region from their neighbours. The 1 MB ends expose off-by-one errors at each 4 MB limit step and at the window edges. Limits 3 and 4 show whether the window enable is gated by the limit. The sector/line combinations show whether the excluded region really outranks the sector rule and whether a valid line is wrongly allocated. The reserved bit is toggled during the sweep, so a leak from it into the decision shows as a mismatch.

// File: rtl/walloc_pkg.sv
package walloc_pkg;

    typedef enum logic [2:0] {
        RSN_ABOVE_LIMIT = 3'd0,
        RSN_SECTOR      = 3'd1,
        RSN_BELOW_LIMIT = 3'd2,
        RSN_WIN_ON      = 3'd3,
        RSN_WIN_OFF     = 3'd4,
        RSN_HOLE        = 3'd5
    } reason_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } state_e;

    typedef struct packed {
        logic hole;
        logic win;
        logic below;
        logic win_armed;
    } region_t;

endpackage

// File: rtl/walloc_region.sv
module walloc_region
    import walloc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LIMIT_W   = 7,
    parameter int LIMIT_LSB = 22,
    parameter int MB_LSB    = 20,
    parameter logic [ADDR_W-1:0] HOLE_LO = 32'h000A_0000,
    parameter logic [ADDR_W-1:0] HOLE_HI = 32'h000F_FFFF,
    parameter int WIN_MB    = 15
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LIMIT_W-1:0] limit,
    output region_t            region
);
    localparam int CMP_W    = ADDR_W - LIMIT_LSB;
    localparam int MB_W     = ADDR_W - MB_LSB;
    localparam int WIN_UNIT = ((WIN_MB + 1) << MB_LSB) >> LIMIT_LSB;

    always_comb begin
        region.hole      = (addr >= HOLE_LO) && (addr <= HOLE_HI);
        region.win       = (addr[ADDR_W-1:MB_LSB] == MB_W'(WIN_MB));
        region.below     = (addr[ADDR_W-1:LIMIT_LSB] < CMP_W'(limit));
        region.win_armed = (int'(limit) >= WIN_UNIT);
    end
endmodule

// File: rtl/walloc_arbiter.sv
module walloc_arbiter
    import walloc_pkg::*;
(
    input  region_t region,
    input  logic    sector_hit,
    input  logic    line_valid,
    input  logic    win_en,
    output logic    alloc,
    output reason_e reason
);
    always_comb begin
        if (region.hole) begin
            alloc  = 1'b0;
            reason = RSN_HOLE;
        end else if (sector_hit && !line_valid) begin
            alloc  = 1'b1;
            reason = RSN_SECTOR;
        end else if (region.win && region.win_armed) begin
            alloc  = win_en;
            reason = win_en ? RSN_WIN_ON : RSN_WIN_OFF;
        end else if (region.below) begin
            alloc  = 1'b1;
            reason = RSN_BELOW_LIMIT;
        end else begin
            alloc  = 1'b0;
            reason = RSN_ABOVE_LIMIT;
        end
    end
endmodule

// File: rtl/walloc_top.sv
module walloc_top
    import walloc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               sector_hit,
    input  logic               line_valid,
    input  logic [LIMIT_W+1:0] cfg_word,
    output logic               dec_valid,
    output logic               dec_alloc,
    output logic [2:0]         dec_reason,
    output logic               cfg_err
);
    localparam int EN_BIT  = LIMIT_W;
    localparam int RSV_BIT = LIMIT_W + 1;

    state_e  state_q, state_d;
    region_t region;
    logic    alloc_c;
    reason_e reason_c;
    logic    alloc_q;
    reason_e reason_q;
    logic    cfg_err_q;

    walloc_region #(
        .ADDR_W (ADDR_W),
        .LIMIT_W(LIMIT_W)
    ) u_region (
        .addr  (wr_addr),
        .limit (cfg_word[LIMIT_W-1:0]),
        .region(region)
    );

    walloc_arbiter u_arb (
        .region    (region),
        .sector_hit(sector_hit),
        .line_valid(line_valid),
        .win_en    (cfg_word[EN_BIT]),
        .alloc     (alloc_c),
        .reason    (reason_c)
    );

    // next-state: T_ACCEPT, T_STREAM, T_DRAIN, T_WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_valid)  state_d = ST_ISSUE;
            ST_ISSUE: if (!wr_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alloc_q   <= 1'b0;
            reason_q  <= RSN_ABOVE_LIMIT;
            cfg_err_q <= 1'b0;
        end else begin
            cfg_err_q <= cfg_word[RSV_BIT];
            if (wr_valid) begin
                alloc_q  <= alloc_c;
                reason_q <= reason_c;
            end else begin
                alloc_q  <= 1'b0;
                reason_q <= RSN_ABOVE_LIMIT;
            end
        end
    end

    assign dec_valid  = (state_q == ST_ISSUE);
    assign dec_alloc  = alloc_q;
    assign dec_reason = reason_q;
    assign cfg_err    = cfg_err_q;
endmodule

// File: rtl/walloc_checker.sv
module walloc_checker #(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic               sector_hit,
    input logic               line_valid,
    input logic [LIMIT_W+1:0] cfg_word,
    input logic               dec_valid,
    input logic               dec_alloc,
    input logic [2:0]         dec_reason,
    input logic               cfg_err
);
    logic [63:0] a64, lim_bytes;
    logic        in_hole, in_win, armed, sec_rule;

    always_comb begin
        a64       = 64'(wr_addr);
        lim_bytes = 64'(cfg_word[LIMIT_W-1:0]) * 64'd4194304;
        in_hole   = (a64 >= 64'h000A_0000) && (a64 <= 64'h000F_FFFF);
        in_win    = (a64 >= 64'h00F0_0000) && (a64 < 64'h0100_0000);
        armed     = (lim_bytes >= 64'h0100_0000);
        sec_rule  = sector_hit && !line_valid;
    end

    p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> dec_valid);
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (!dec_valid && !dec_alloc && dec_reason == 3'd0));
    p_hole_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && in_hole) |=> (!dec_alloc && dec_reason == 3'd5));
    p_sector_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !in_hole && sec_rule) |=> (dec_alloc && dec_reason == 3'd1));
    p_win_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !sec_rule && in_win && armed && cfg_word[LIMIT_W])
        |=> (dec_alloc && dec_reason == 3'd3));
    p_win_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !sec_rule && in_win && armed && !cfg_word[LIMIT_W])
        |=> (!dec_alloc && dec_reason == 3'd4));
    p_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !sec_rule && !in_hole && !in_win && a64 < lim_bytes)
        |=> (dec_alloc && dec_reason == 3'd2));
    p_limit_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !sec_rule && lim_bytes == 64'd0) |=> !dec_alloc);
    p_cfg_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cfg_err == $past(cfg_word[LIMIT_W+1])));
endmodule

bind walloc_top walloc_checker #(
    .ADDR_W (ADDR_W),
    .LIMIT_W(LIMIT_W)
) u_walloc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .sector_hit(sector_hit),
    .line_valid(line_valid),
    .cfg_word  (cfg_word),
    .dec_valid (dec_valid),
    .dec_alloc (dec_alloc),
    .dec_reason(dec_reason),
    .cfg_err   (cfg_err)
);

// File: tb/walloc_top_bench.sv
module walloc_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic        sector_hit = 1'b0;
    logic        line_valid = 1'b0;
    logic [8:0]  cfg_word = '0;
    logic        dec_valid, dec_alloc, cfg_err;
    logic [2:0]  dec_reason;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    walloc_top u_walloc_top (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .sector_hit(sector_hit), .line_valid(line_valid), .cfg_word(cfg_word),
        .dec_valid(dec_valid), .dec_alloc(dec_alloc), .dec_reason(dec_reason),
        .cfg_err(cfg_err)
    );

    function automatic logic [31:0] addr_at(int k, int off);
        longint b;
        if (k < 32)       b = longint'(k) * 65536 + (off ? 65535 : 0);
        else if (k < 96)  b = longint'(k - 32) * 1048576 + (off ? 1048575 : 0);
        else if (k == 96) b = off ? 64'hFFFF_FFFF : 64'h8000_0000;
        else if (k == 97) b = off ? 64'h1FC0_0000 : 64'h1FBF_FFFF;
        else if (k == 98) b = off ? 64'h0100_0000 : 64'h00FF_FFFF;
        else              b = off ? 64'h0010_0000 : 64'h0009_FFFF;
        return b[31:0];
    endfunction

    // returns {alloc, reason}; tag names the requirement
    function automatic logic [3:0] model(logic [31:0] addr, logic sh, logic lv,
                                         int lim, logic en, output string tag);
        longint a  = longint'(addr);
        longint lb = longint'(lim) * 4194304;
        if (a >= 'hA0000 && a <= 'hFFFFF) begin tag = "R3"; return {1'b0, 3'd5}; end
        if (sh && !lv)                   begin tag = "R1"; return {1'b1, 3'd1}; end
        if (a >= 15*1048576 && a < 16*1048576 && lb >= 16*1048576) begin
            if (en) begin tag = "R4"; return {1'b1, 3'd3}; end
            tag = "R5"; return {1'b0, 3'd4};
        end
        if (a < lb) begin tag = "R2"; return {1'b1, 3'd2}; end
        tag = "R6";
        return {1'b0, 3'd0};
    endfunction

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,alloc,reason,cfg_err} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [31:0] addr, logic sh, logic lv, int lim, logic en, logic rsv);
        string tag;
        logic [3:0] e;
        wr_valid   = 1'b1;
        wr_addr    = addr;
        sector_hit = sh;
        line_valid = lv;
        cfg_word   = {rsv, en, 7'(lim)};
        @(negedge clk);
        e = model(addr, sh, lv, lim, en, tag);
        check(tag, {dec_valid, dec_alloc, dec_reason, cfg_err}, {1'b1, e, rsv});
    endtask

    task automatic do_idle(logic rsv);
        wr_valid = 1'b0;
        cfg_word[8] = rsv;
        @(negedge clk);
        check("R7", {dec_valid, dec_alloc, dec_reason, cfg_err}, {5'b0, rsv});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lims[19];
        for (int i = 0; i < 18; i++) lims[i] = i;
        lims[18] = 127;

        // R9: outputs held at zero under reset, even with inputs active
        wr_valid = 1'b1; cfg_word = 9'h1FF; sector_hit = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", {dec_valid, dec_alloc, dec_reason, cfg_err}, 6'b0);
        wr_valid = 1'b0; cfg_word = '0; sector_hit = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", {dec_valid, dec_alloc, dec_reason, cfg_err}, 6'b0);

        // main sweep: R1..R6, R8 (reserved bit toggled)
        for (int li = 0; li < 19; li++) begin
            for (int en = 0; en < 2; en++) begin
                for (int k = 0; k < 100; k++) begin
                    for (int off = 0; off < 2; off++) begin
                        for (int f = 0; f < 4; f++) begin
                            do_write(addr_at(k, off), f[1], f[0], lims[li], en[0],
                                     logic'((k + f + li) % 3 == 0));
                        end
                    end
                end
                // R7: gap between bursts drops dec_valid
                do_idle(logic'(en));
            end
        end

        // R7: isolated write then two idle cycles
        do_write(32'h0020_0000, 1'b0, 1'b0, 1, 1'b0, 1'b0);
        do_idle(1'b0);
        do_idle(1'b1);
        // R8: reserved bit alone does not allocate
        do_write(32'h0400_0000, 1'b0, 1'b1, 0, 1'b1, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule